// File: doc/BRIEF.md
# DRAM Request Arbiter with Refresh

This block decides which of four requesters the DRAM controller serves next. The requesters are a periodic refresh, an I/O-to-memory requester, a CPU memory requester and a CPU I/O requester. The I/O-to-memory request is raised either by an expansion card or by a DMA engine. Each asynchronous request line passes through a synchronizer into the system clock domain. Among the requests that are eligible, a fixed-priority stage picks one and issues a one-hot grant. That grant stays on until the controller pulses `acc_done`.

Refresh is generated inside the block. A counter advances on a 1 MHz strobe and, after a fixed number of strobes, sets a refresh request flip-flop. A row counter steps each time a refresh access completes. Because every access ends with a new arbitration, a pending refresh can win the bus between two beats of a DMA block transfer. It can also win between the halves of a locked CPU read-modify-write. Refresh timing and refresh grants keep running during system reset, so memory contents survive it. Only the power-on reset clears the refresh state.

The grant state machine has five states:
- `ST_IDLE` is the arbitration cycle.
- `ST_REFRESH`, `ST_IO_MEM`, `ST_CPU_MEM` and `ST_CPU_IO` are the four serving states.

It has three kinds of transition:
- issue: `ST_IDLE` moves to the serving state of the winner.
- finish: a serving state returns to `ST_IDLE` on `acc_done`.
- abort: a non-refresh serving state returns to `ST_IDLE` when `sys_rst` is high.

Top module: `dram_req_arbiter`

## Requirements
- R1: `grant` is zero or one-hot. Bit 3 is refresh, bit 2 is I/O-to-memory, bit 1 is CPU memory and bit 0 is CPU I/O.
- R2: When several eligible requests are seen in the same arbitration cycle, the winner is chosen in this order: refresh, then I/O-to-memory, then CPU memory, then CPU I/O.
- R3: The I/O-to-memory request is the OR of `card_req` and `dma_req`. Either input alone produces grant bit 2.
- R4: Each request input passes through two synchronizer flops. With the arbiter idle, a request driven before rising edge 1 is first granted at rising edge 3, and `grant` is still zero after edge 2.
- R5: A grant stays unchanged until `acc_done` is sampled high. At that edge `grant` goes to zero, and it stays zero for at least one full cycle before any next grant.
- R6: The refresh request is set on every 16th `tick_1mhz` strobe counted since power-on. Fifteen strobes do not raise it. It is cleared when the refresh grant is issued.
- R7: `refresh_row` increases by one, modulo 2^ROW_W, on the edge where `acc_done` is sampled during a refresh grant. At all other times it holds its value.
- R8: `refresh_missed` is set when a refresh period ends while the previous refresh request has not yet been granted. It is cleared on the edge where the refresh grant is issued.
- R9: While `cpu_lock` is high, the arbiter grants only refresh or CPU memory. I/O-to-memory and CPU I/O requests wait until the lock drops.
- R10: When the I/O-to-memory requester keeps its request high across beats, a refresh that became pending during a beat is granted before the next beat.
- R11: While `sys_rst` is high, a current non-refresh grant is dropped at the next edge and no non-refresh grant is issued. Refresh timing, refresh grants and the row counter keep working.
- R12: With `por_n` low, `grant`, `refresh_row` and `refresh_missed` are zero, and the refresh strobe count restarts from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_n | input | 1 | Power-on reset, asynchronous, active low |
| sys_rst | input | 1 | System reset, synchronous, active high; blocks non-refresh service |
| tick_1mhz | input | 1 | 1 MHz strobe, one clock cycle wide per tick |
| card_req | input | 1 | Expansion-card memory request, asynchronous level |
| dma_req | input | 1 | DMA engine memory request, asynchronous level |
| cpu_mem_req | input | 1 | CPU memory request, asynchronous level |
| cpu_io_req | input | 1 | CPU I/O request, asynchronous level |
| cpu_lock | input | 1 | Locked CPU operation in progress, synchronous |
| acc_done | input | 1 | Access complete pulse from the controller |
| grant | output | 4 | One-hot grant: [3] refresh, [2] I/O-mem, [1] CPU mem, [0] CPU I/O |
| refresh_row | output | ROW_W | Row to refresh; steps after each refresh access |
| refresh_missed | output | 1 | A refresh period ended with the previous refresh still waiting |

## Verification
The bench applies four input patterns, each aimed at one property:
- Requests raised one at a time separate synchronizer latency and the OR of the card and DMA inputs from any priority effect.
- Requests raised together in one cycle show the priority order in the sequence of grants.
- A DMA request held across beats while strobes arrive in mid-beat shows whether refresh cuts in between beats rather than waiting for the whole transfer.
- Runs under `cpu_lock` and under `sys_rst` show that the masking hides the right requests while refresh still passes through.

A long CPU grant spanning two refresh periods tells a lost refresh apart from a late one.

// File: rtl/dram_arb_pkg.sv
package dram_arb_pkg;

    localparam int NUM_SRC  = 4;
    localparam int SRC_REF  = 3;
    localparam int SRC_IO   = 2;
    localparam int SRC_CMEM = 1;
    localparam int SRC_CIO  = 0;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_REFRESH,
        ST_IO_MEM,
        ST_CPU_MEM,
        ST_CPU_IO
    } arb_state_e;

endpackage

// File: rtl/dram_req_sync.sv
module dram_req_sync #(
    parameter int WIDTH  = 4,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             por_n,
    input  logic [WIDTH-1:0] d_async,
    output logic [WIDTH-1:0] q_sync
);

    localparam int LAST = STAGES - 1;

    generate
        for (genvar b = 0; b < WIDTH; b++) begin : g_bit
            logic [STAGES-1:0] chain;

            always_ff @(posedge clk or negedge por_n) begin
                if (!por_n) begin
                    chain <= '0;
                end else begin
                    chain <= {chain[STAGES-2:0], d_async[b]};
                end
            end

            assign q_sync[b] = chain[LAST];
        end
    endgenerate

endmodule

// File: rtl/dram_refresh_timer.sv
module dram_refresh_timer #(
    parameter int PERIOD_TICKS = 16,
    parameter int ROW_W        = 8
) (
    input  logic             clk,
    input  logic             por_n,
    input  logic             tick,
    input  logic             grant_issue,
    input  logic             refresh_done,
    output logic             ref_req,
    output logic             ref_missed,
    output logic [ROW_W-1:0] row
);

    localparam int CNT_W = (PERIOD_TICKS > 2) ? $clog2(PERIOD_TICKS) : 1;
    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(PERIOD_TICKS - 1);

    logic [CNT_W-1:0] tick_cnt;
    logic             period_end;

    assign period_end = tick && (tick_cnt == LAST_CNT);

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            tick_cnt <= '0;
        end else if (tick) begin
            tick_cnt <= period_end ? '0 : tick_cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            ref_req <= 1'b0;
        end else if (period_end) begin
            ref_req <= 1'b1;
        end else if (grant_issue) begin
            ref_req <= 1'b0;
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            ref_missed <= 1'b0;
        end else if (period_end && ref_req && !grant_issue) begin
            ref_missed <= 1'b1;
        end else if (grant_issue) begin
            ref_missed <= 1'b0;
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            row <= '0;
        end else if (refresh_done) begin
            row <= row + 1'b1;
        end
    end

endmodule

// File: rtl/dram_grant_fsm.sv
module dram_grant_fsm
    import dram_arb_pkg::*;
(
    input  logic               clk,
    input  logic               por_n,
    input  logic               sys_rst,
    input  logic               cpu_lock,
    input  logic               acc_done,
    input  logic [NUM_SRC-1:0] req,
    output logic [NUM_SRC-1:0] grant,
    output logic               ref_issue,
    output logic               ref_done
);

    arb_state_e         state_q, state_d;
    logic [NUM_SRC-1:0] eligible;
    logic [NUM_SRC-1:0] winner;

    // masking by system reset and by a locked CPU sequence
    always_comb begin
        eligible = req;
        if (sys_rst) begin
            eligible[SRC_IO]   = 1'b0;
            eligible[SRC_CMEM] = 1'b0;
            eligible[SRC_CIO]  = 1'b0;
        end
        if (cpu_lock) begin
            eligible[SRC_IO]  = 1'b0;
            eligible[SRC_CIO] = 1'b0;
        end
    end

    // fixed priority, highest index first
    always_comb begin
        logic taken;
        taken  = 1'b0;
        winner = '0;
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (eligible[i] && !taken) begin
                winner[i] = 1'b1;
                taken     = 1'b1;
            end
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (winner[SRC_REF])       state_d = ST_REFRESH;
                else if (winner[SRC_IO])   state_d = ST_IO_MEM;
                else if (winner[SRC_CMEM]) state_d = ST_CPU_MEM;
                else if (winner[SRC_CIO])  state_d = ST_CPU_IO;
            end
            ST_REFRESH: begin
                if (acc_done) state_d = ST_IDLE;
            end
            ST_IO_MEM, ST_CPU_MEM, ST_CPU_IO: begin
                if (sys_rst || acc_done) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        grant     = '0;
        ref_issue = 1'b0;
        ref_done  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                ref_issue = (state_d == ST_REFRESH);
            end
            ST_REFRESH: begin
                grant[SRC_REF] = 1'b1;
                ref_done       = acc_done;
            end
            ST_IO_MEM:  grant[SRC_IO]   = 1'b1;
            ST_CPU_MEM: grant[SRC_CMEM] = 1'b1;
            ST_CPU_IO:  grant[SRC_CIO]  = 1'b1;
            default: grant = '0;
        endcase
    end

endmodule

// File: rtl/dram_req_arbiter.sv
module dram_req_arbiter
    import dram_arb_pkg::*;
#(
    parameter int SYNC_STAGES   = 2,
    parameter int REFRESH_TICKS = 16,
    parameter int ROW_W         = 8
) (
    input  logic             clk,
    input  logic             por_n,
    input  logic             sys_rst,
    input  logic             tick_1mhz,
    input  logic             card_req,
    input  logic             dma_req,
    input  logic             cpu_mem_req,
    input  logic             cpu_io_req,
    input  logic             cpu_lock,
    input  logic             acc_done,
    output logic [3:0]       grant,
    output logic [ROW_W-1:0] refresh_row,
    output logic             refresh_missed
);

    localparam int N_ASYNC = 4;

    logic [N_ASYNC-1:0] raw_req;
    logic [N_ASYNC-1:0] sync_req;
    logic [NUM_SRC-1:0] arb_req;
    logic               ref_pending;
    logic               ref_issue;
    logic               ref_done;

    assign raw_req = {card_req, dma_req, cpu_mem_req, cpu_io_req};

    dram_req_sync #(
        .WIDTH  (N_ASYNC),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk     (clk),
        .por_n   (por_n),
        .d_async (raw_req),
        .q_sync  (sync_req)
    );

    always_comb begin
        arb_req           = '0;
        arb_req[SRC_REF]  = ref_pending;
        arb_req[SRC_IO]   = sync_req[3] | sync_req[2];
        arb_req[SRC_CMEM] = sync_req[1];
        arb_req[SRC_CIO]  = sync_req[0];
    end

    dram_refresh_timer #(
        .PERIOD_TICKS (REFRESH_TICKS),
        .ROW_W        (ROW_W)
    ) u_refresh (
        .clk          (clk),
        .por_n        (por_n),
        .tick         (tick_1mhz),
        .grant_issue  (ref_issue),
        .refresh_done (ref_done),
        .ref_req      (ref_pending),
        .ref_missed   (refresh_missed),
        .row          (refresh_row)
    );

    dram_grant_fsm u_fsm (
        .clk       (clk),
        .por_n     (por_n),
        .sys_rst   (sys_rst),
        .cpu_lock  (cpu_lock),
        .acc_done  (acc_done),
        .req       (arb_req),
        .grant     (grant),
        .ref_issue (ref_issue),
        .ref_done  (ref_done)
    );

endmodule

// File: rtl/dram_req_arbiter_checker.sv
module dram_req_arbiter_checker #(
    parameter int ROW_W = 8
) (
    input logic             clk,
    input logic             por_n,
    input logic             sys_rst,
    input logic             cpu_lock,
    input logic             acc_done,
    input logic [3:0]       arb_req,
    input logic [3:0]       grant,
    input logic [ROW_W-1:0] refresh_row,
    input logic             refresh_missed
);

    assert_onehot_grant_R1: assert property (@(posedge clk) disable iff (!por_n)
        $onehot0(grant));

    assert_refresh_first_R2: assert property (@(posedge clk) disable iff (!por_n)
        (grant == 4'b0000 && arb_req[3]) |=> grant[3]);

    assert_hold_grant_R5: assert property (@(posedge clk) disable iff (!por_n)
        (grant != 4'b0000 && !acc_done && !(sys_rst && !grant[3])) |=> grant == $past(grant));

    assert_gap_after_done_R5: assert property (@(posedge clk) disable iff (!por_n)
        (grant != 4'b0000 && acc_done) |=> grant == 4'b0000);

    assert_row_step_R7: assert property (@(posedge clk) disable iff (!por_n)
        (grant[3] && acc_done) |=> refresh_row == ROW_W'($past(refresh_row) + 1'b1));

    assert_row_hold_R7: assert property (@(posedge clk) disable iff (!por_n)
        !(grant[3] && acc_done) |=> $stable(refresh_row));

    assert_missed_cleared_R8: assert property (@(posedge clk) disable iff (!por_n)
        $rose(grant[3]) |-> !refresh_missed);

    assert_lock_mask_R9: assert property (@(posedge clk) disable iff (!por_n)
        (grant == 4'b0000 && cpu_lock) |=> (!grant[2] && !grant[0]));

    assert_sysrst_mask_R11: assert property (@(posedge clk) disable iff (!por_n)
        sys_rst |=> (grant[2:0] == 3'b000));

endmodule

bind dram_req_arbiter dram_req_arbiter_checker #(.ROW_W(ROW_W)) u_checker (
    .clk            (clk),
    .por_n          (por_n),
    .sys_rst        (sys_rst),
    .cpu_lock       (cpu_lock),
    .acc_done       (acc_done),
    .arb_req        (arb_req),
    .grant          (grant),
    .refresh_row    (refresh_row),
    .refresh_missed (refresh_missed)
);

// File: tb/dram_req_arbiter_bench.sv
module dram_req_arbiter_bench;

    localparam int ROW_W = 8;

    logic             clk = 1'b0;
    logic             por_n = 1'b0;
    logic             sys_rst = 1'b0;
    logic             tick_1mhz = 1'b0;
    logic             card_req = 1'b0;
    logic             dma_req = 1'b0;
    logic             cpu_mem_req = 1'b0;
    logic             cpu_io_req = 1'b0;
    logic             cpu_lock = 1'b0;
    logic             acc_done = 1'b0;
    logic [3:0]       grant;
    logic [ROW_W-1:0] refresh_row;
    logic             refresh_missed;

    int    n_checks = 0;
    int    n_fail   = 0;
    int    exp_row  = 0;
    bit    finished = 1'b0;
    logic [3:0] exp_q[$];
    string      tag_q[$];
    logic [3:0] prev_grant = 4'b0000;

    always #4 clk = ~clk;

    dram_req_arbiter #(.ROW_W(ROW_W)) u_dram_req_arbiter (
        .clk            (clk),
        .por_n          (por_n),
        .sys_rst        (sys_rst),
        .tick_1mhz      (tick_1mhz),
        .card_req       (card_req),
        .dma_req        (dma_req),
        .cpu_mem_req    (cpu_mem_req),
        .cpu_io_req     (cpu_io_req),
        .cpu_lock       (cpu_lock),
        .acc_done       (acc_done),
        .grant          (grant),
        .refresh_row    (refresh_row),
        .refresh_missed (refresh_missed)
    );

    task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    // monitor: every new grant is compared with the head of the scoreboard
    always @(negedge clk) begin
        if (por_n && grant != 4'b0000 && prev_grant == 4'b0000) begin
            if (exp_q.size() == 0) begin
                chk("R2", "unexpected grant", grant, 4'b0000);
            end else begin
                logic [3:0] e;
                string      t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                chk(t, "grant order", grant, e);
            end
        end
        prev_grant = grant;
    end

    task automatic fire_ticks(input int n);
        for (int i = 0; i < n; i++) begin
            tick_1mhz = 1'b1;
            @(negedge clk);
        end
        tick_1mhz = 1'b0;
    endtask

    task automatic drop_req(input logic [3:0] g);
        if (g[2]) begin card_req = 1'b0; dma_req = 1'b0; end
        if (g[1]) cpu_mem_req = 1'b0;
        if (g[0]) cpu_io_req = 1'b0;
    endtask

    // driver: expect one grant, hold the access, then finish it
    task automatic serve(input logic [3:0] exp, input string tag, input bit keep, input int n_ticks);
        int         guard;
        int         hold;
        logic [3:0] held;
        bit         stable_ok;
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        guard = 0;
        while (grant == 4'b0000 && guard < 300) begin
            @(negedge clk);
            guard++;
        end
        chk(tag, "grant arrived", grant != 4'b0000, 1);
        if (!keep) drop_req(exp);
        held = grant;
        if (exp[3]) chk("R7", "row during refresh", refresh_row, exp_row[ROW_W-1:0]);
        hold = (n_ticks > 2) ? n_ticks : 2;
        stable_ok = 1'b1;
        for (int i = 0; i < hold; i++) begin
            tick_1mhz = (i < n_ticks);
            @(negedge clk);
            if (grant !== held) stable_ok = 1'b0;
        end
        tick_1mhz = 1'b0;
        chk("R5", "grant held until done", stable_ok, 1);
        acc_done = 1'b1;
        @(negedge clk);
        acc_done = 1'b0;
        chk("R5", "grant off after done", grant, 4'b0000);
        if (exp[3]) begin
            exp_row++;
            chk("R7", "row after refresh", refresh_row, exp_row[ROW_W-1:0]);
        end
    endtask

    initial begin
        // R12 power-on state
        cyc(3);
        chk("R12", "grant in reset", grant, 4'b0000);
        chk("R12", "row in reset", refresh_row, 0);
        chk("R12", "missed in reset", refresh_missed, 0);
        por_n = 1'b1;
        cyc(2);

        // R4 latency and R1 encoding
        cpu_io_req = 1'b1;
        cyc(2);
        chk("R4", "no grant after two edges", grant, 4'b0000);
        serve(4'b0001, "R4", 0, 0);
        cyc(3);

        // R3 either source of the I/O-to-memory request
        card_req = 1'b1;
        serve(4'b0100, "R3", 0, 0);
        cyc(3);
        dma_req = 1'b1;
        serve(4'b0100, "R3", 0, 0);
        cyc(3);

        // R2 simultaneous requests
        card_req = 1'b1; cpu_mem_req = 1'b1; cpu_io_req = 1'b1;
        serve(4'b0100, "R2", 0, 0);
        serve(4'b0010, "R2", 0, 0);
        serve(4'b0001, "R2", 0, 0);
        cyc(3);

        // R6 refresh period of 16 strobes
        fire_ticks(15);
        cyc(4);
        chk("R6", "no refresh after 15 strobes", grant, 4'b0000);
        fire_ticks(1);
        serve(4'b1000, "R6", 0, 0);
        chk("R8", "no miss after timely refresh", refresh_missed, 0);
        cyc(3);

        // R10 refresh between block transfer beats
        dma_req = 1'b1;
        serve(4'b0100, "R10", 1, 16);
        serve(4'b1000, "R10", 0, 0);
        serve(4'b0100, "R10", 0, 0);
        cyc(3);

        // R8 two periods pass during a long access
        cpu_io_req = 1'b1;
        serve(4'b0001, "R8", 0, 32);
        chk("R8", "missed flag raised", refresh_missed, 1);
        serve(4'b1000, "R8", 0, 0);
        chk("R8", "missed flag cleared", refresh_missed, 0);
        cyc(3);

        // R9 locked CPU sequence
        cpu_lock = 1'b1;
        card_req = 1'b1; cpu_mem_req = 1'b1; cpu_io_req = 1'b1;
        serve(4'b0010, "R9", 0, 0);
        cyc(6);
        chk("R9", "I/O requests blocked under lock", grant, 4'b0000);
        fire_ticks(16);
        serve(4'b1000, "R9", 0, 0);
        cpu_lock = 1'b0;
        serve(4'b0100, "R9", 0, 0);
        serve(4'b0001, "R9", 0, 0);
        cyc(3);

        // R11 system reset
        cpu_mem_req = 1'b1;
        exp_q.push_back(4'b0010);
        tag_q.push_back("R11");
        begin
            int guard = 0;
            while (grant == 4'b0000 && guard < 50) begin
                @(negedge clk);
                guard++;
            end
        end
        cpu_mem_req = 1'b0;
        sys_rst = 1'b1;
        cyc(1);
        chk("R11", "grant dropped by system reset", grant, 4'b0000);
        card_req = 1'b1;
        cyc(6);
        chk("R11", "no I/O grant in system reset", grant, 4'b0000);
        fire_ticks(16);
        serve(4'b1000, "R11", 0, 0);
        sys_rst = 1'b0;
        serve(4'b0100, "R11", 0, 0);
        cyc(4);

        chk("R2", "all expected grants seen", exp_q.size(), 0);
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        finished = 1'b1;
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL R5 watchdog: actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

endmodule